// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host processor reach the registers of external Ethernet PHYs over the two-wire management bus. It sits on a simple 32-bit register bus: single-cycle writes, with read data returned combinationally for the word offset on the address lines. It generates the management clock and drives or samples the data line, using clause-22 frames of 64 bit periods each.

Each transaction type has its own trigger. Software first loads the target PHY and register numbers. A write frame starts when the write-data register is written. A read frame starts when the read-trigger bit goes from 0 to 1. A busy flag covers every frame in progress. A separate not-valid flag covers a read until its captured data reaches the status register.

The management clock is the system clock divided by a parameter, 112 by default. A reset bit in the configuration register aborts any frame in progress and holds the sequencer idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register offset (0 to 7) reads zero, MDC is low and the data output enable is low.
- R2: The address register at offset 1 holds the PHY address in bits 12:8 and the register number in bits 4:0. All other bits read zero.
- R3: A write to offset 2 while idle stores bits 15:0 and starts a write frame. The frame is sent MSB first: 32 ones, start bits 0 then 1, opcode 0 then 1, the 5-bit PHY address, the 5-bit register number, turnaround 1 then 0, then the 16 data bits. Each bit is held for one full MDC period and changes only at period boundaries.
- R4: Offset 3 bit 0 is the read trigger. A read frame starts only when a write sets it while its stored value is 0. Writing 1 when it is already 1 starts nothing.
- R5: A read frame sends opcode 1 then 0. The output enable is low from bit 46 through bit 63. MDIO input is sampled on the MDC rising edge of bits 48 to 63, MSB first. The 16 sampled bits then read back at offset 4.
- R6: Offset 5 holds busy in bit 0 and not-valid in bit 2. Busy is set from the cycle after a frame starts. Not-valid is set with it for reads only. Both clear at the clock edge that completes the last MDC period.
- R7: MDC runs only during a frame. Each of the 64 periods lasts DIV system clocks (default 112): low for the first DIV/2 clocks and high for the rest. MDC is low while idle.
- R8: Writes to offsets 1, 2 and 3 are ignored while busy is set.
- R9: Offset 0 holds a reset bit at bit 31 and a 4-bit divider select in bits 3:0. While the reset bit is set, the frame in progress stops at the next edge, offsets 3 and 4 are cleared, and frame triggers are ignored.
- R10: Offset 6 holds a 5-bit TBI address in bits 4:0. It is writable at any time, busy included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the offset on reg_addr |
| mdio_i | input | 1 | Sampled management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven management data value |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The assertions assume the register bus presents one offset per write strobe. They also assume the reset bit is cleared only after the sequencer has returned to idle. The bench drives every bus write for one full cycle, shortly after a rising edge, and waits for the busy flag to clear before each new frame, apart from the writes deliberately made during a frame to show they are refused. The PHY responder changes MDIO only on falling clock edges, so the value sampled at the MDC rise is never in transition.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        OFS_CFG  = 3'd0,
        OFS_ADDR = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_CMD  = 3'd3,
        OFS_STAT = 3'd4,
        OFS_IND  = 3'd5,
        OFS_TBI  = 3'd6
    } reg_ofs_e;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_BIT     = 46;
    localparam int DATA_BIT   = 48;
    localparam int PHY_W      = 5;
    localparam int REGN_W     = 5;
    localparam int DATA_W     = 16;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] TA_WR    = 2'b10;

    typedef struct packed {
        logic       rst;
        logic [3:0] clksel;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic [PHY_W-1:0]  phy;
        logic [REGN_W-1:0] regn;
        logic [DATA_W-1:0] ctrl;
        logic              cmd;
        logic [DATA_W-1:0] stat;
        logic [4:0]        tbi;
    } regs_t;

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy_i,
    input  logic              nvalid_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              start_wr_o,
    output logic              start_rd_o,
    output logic              soft_rst_o,
    output logic [PHY_W-1:0]  phy_o,
    output logic [REGN_W-1:0] regn_o,
    output logic [DATA_W-1:0] wdata_o
);

    regs_t r_d, r_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[30:16], wdata[7:5]};

    always_comb begin
        r_d        = r_q;
        start_wr_o = 1'b0;
        start_rd_o = 1'b0;
        if (wen) begin
            case (reg_ofs_e'(addr))
                OFS_CFG: begin
                    r_d.cfg.rst    = wdata[31];
                    r_d.cfg.clksel = wdata[3:0];
                end
                OFS_ADDR: if (!busy_i) begin
                    r_d.phy  = wdata[12:8];
                    r_d.regn = wdata[4:0];
                end
                OFS_CTRL: if (!busy_i) begin
                    r_d.ctrl   = wdata[15:0];
                    start_wr_o = !r_q.cfg.rst;
                end
                OFS_CMD: if (!busy_i) begin
                    r_d.cmd    = wdata[0];
                    start_rd_o = wdata[0] && !r_q.cmd && !r_q.cfg.rst;
                end
                OFS_TBI: r_d.tbi = wdata[4:0];
                default: ;
            endcase
        end
        if (rd_done_i) r_d.stat = rd_data_i;
        if (r_q.cfg.rst) begin
            r_d.stat = '0;
            r_d.cmd  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (reg_ofs_e'(addr))
            OFS_CFG:  rdata = {r_q.cfg.rst, 27'd0, r_q.cfg.clksel};
            OFS_ADDR: rdata = {19'd0, r_q.phy, 3'd0, r_q.regn};
            OFS_CTRL: rdata = {16'd0, r_q.ctrl};
            OFS_CMD:  rdata = {31'd0, r_q.cmd};
            OFS_STAT: rdata = {16'd0, r_q.stat};
            OFS_IND:  rdata = {29'd0, nvalid_i, 1'b0, busy_i};
            OFS_TBI:  rdata = {27'd0, r_q.tbi};
            default:  rdata = '0;
        endcase
    end

    assign soft_rst_o = r_q.cfg.rst;
    assign phy_o      = r_q.phy;
    assign regn_o     = r_q.regn;
    assign wdata_o    = wdata[15:0];

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable({r_q.phy, r_q.regn, r_q.ctrl}));

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !r_q.cfg.rst) |=> $stable(r_q.cmd));

    assert_softrst_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg.rst |=> (r_q.stat == '0 && !r_q.cmd));

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int DIV = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              soft_rst,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REGN_W-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              nvalid,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DW   = $clog2(DIV);
    localparam int HALF = DIV / 2;
    localparam int BW   = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic                  nv;
        logic [DW-1:0]         div;
        logic [BW-1:0]         bitn;
        logic [FRAME_BITS-1:0] frame;
        logic [DATA_W-1:0]     rx;
    } eng_t;

    eng_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        rd_done = 1'b0;
        if (soft_rst) begin
            s_d.busy = 1'b0;
            s_d.nv   = 1'b0;
            s_d.div  = '0;
            s_d.bitn = '0;
        end else if (s_q.busy) begin
            if (s_q.rd && s_q.div == DW'(HALF - 1) && s_q.bitn >= BW'(DATA_BIT))
                s_d.rx = {s_q.rx[DATA_W-2:0], mdio_i};
            if (s_q.div == DW'(DIV - 1)) begin
                s_d.div = '0;
                if (s_q.bitn == BW'(FRAME_BITS - 1)) begin
                    s_d.busy = 1'b0;
                    s_d.nv   = 1'b0;
                    rd_done  = s_q.rd;
                end else begin
                    s_d.bitn = s_q.bitn + 1'b1;
                end
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end else if (start_wr || start_rd) begin
            s_d.busy  = 1'b1;
            s_d.rd    = start_rd;
            s_d.nv    = start_rd;
            s_d.div   = '0;
            s_d.bitn  = '0;
            s_d.rx    = '0;
            s_d.frame = {{PRE_BITS{1'b1}}, SOF_BITS,
                         start_rd ? OP_RD : OP_WR, phy, regn,
                         start_rd ? 2'b00 : TA_WR,
                         start_rd ? {DATA_W{1'b0}} : wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc     = s_q.busy && (s_q.div >= DW'(HALF));
    assign mdio_oe = s_q.busy && !(s_q.rd && s_q.bitn >= BW'(TA_BIT));
    assign mdio_o  = mdio_oe && s_q.frame[BW'(FRAME_BITS - 1) - s_q.bitn];
    assign busy    = s_q.busy;
    assign nvalid  = s_q.nv;
    assign rd_data = s_q.rx;

    assert_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !soft_rst && s_q.div == DW'(DIV - 1) && s_q.bitn == BW'(FRAME_BITS - 1))
        |=> (!s_q.busy && !s_q.nv));

    assert_nv_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.nv |-> s_q.busy);

    assert_bit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !soft_rst && s_q.div == DW'(DIV - 1) && s_q.bitn != BW'(FRAME_BITS - 1))
        |=> (s_q.bitn == $past(s_q.bitn) + 1'b1 && !mdc));

    assert_wr_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !soft_rst && start_wr) |=> (s_q.busy && !s_q.rd && mdio_oe && !mdc));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !s_q.busy);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV = 112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);

    logic              busy, nvalid, rd_done, start_wr, start_rd, soft_rst;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic [PHY_W-1:0]  phy;
    logic [REGN_W-1:0] regn;

    mdio_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (reg_wen),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy_i     (busy),
        .nvalid_i   (nvalid),
        .rd_done_i  (rd_done),
        .rd_data_i  (rd_data),
        .start_wr_o (start_wr),
        .start_rd_o (start_rd),
        .soft_rst_o (soft_rst),
        .phy_o      (phy),
        .regn_o     (regn),
        .wdata_o    (wr_data)
    );

    mdio_engine #(.DIV(DIV)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .soft_rst (soft_rst),
        .phy      (phy),
        .regn     (regn),
        .wdata    (wr_data),
        .mdio_i   (mdio_i),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .nvalid   (nvalid),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;

    localparam int DIV  = 112;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #10 clk = ~clk;

    // behavioural reference state
    logic        m_cfg_rst, m_busy, m_rd, m_nv, m_cmd;
    logic [3:0]  m_clksel;
    logic [4:0]  m_phy, m_reg, m_tbi, m_fphy, m_freg;
    logic [15:0] m_ctrl, m_stat, m_fdata, m_rx;
    int          m_cnt;
    logic [15:0] phy_resp = 16'h0000;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic m_start(input logic rd, input logic [15:0] d);
        m_busy = 1'b1; m_rd = rd; m_nv = rd; m_cnt = 0;
        m_fphy = m_phy; m_freg = m_reg; m_fdata = d; m_rx = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg_rst = 0; m_busy = 0; m_rd = 0; m_nv = 0; m_cmd = 0; m_clksel = 0;
            m_phy = 0; m_reg = 0; m_tbi = 0; m_fphy = 0; m_freg = 0;
            m_ctrl = 0; m_stat = 0; m_fdata = 0; m_rx = 0; m_cnt = 0;
        end else begin
            automatic logic o_busy = m_busy;
            automatic logic o_rst  = m_cfg_rst;
            automatic logic o_cmd  = m_cmd;
            if (o_rst) begin
                m_busy = 0; m_nv = 0; m_cnt = 0;
            end else if (o_busy) begin
                if (m_rd && (m_cnt % DIV) == HALF - 1 && (m_cnt / DIV) >= 48)
                    m_rx = {m_rx[14:0], mdio_i};
                if (m_cnt == 64 * DIV - 1) begin
                    m_busy = 0;
                    if (m_rd) begin m_nv = 0; m_stat = m_rx; end
                end else m_cnt++;
            end
            if (reg_wen) begin
                case (reg_addr)
                    3'd0: begin m_cfg_rst = reg_wdata[31]; m_clksel = reg_wdata[3:0]; end
                    3'd1: if (!o_busy) begin m_phy = reg_wdata[12:8]; m_reg = reg_wdata[4:0]; end
                    3'd2: if (!o_busy) begin
                        m_ctrl = reg_wdata[15:0];
                        if (!o_rst) m_start(1'b0, reg_wdata[15:0]);
                    end
                    3'd3: if (!o_busy) begin
                        if (reg_wdata[0] && !o_cmd && !o_rst) m_start(1'b1, 16'h0);
                        m_cmd = reg_wdata[0];
                    end
                    3'd6: m_tbi = reg_wdata[4:0];
                    default: ;
                endcase
            end
            if (o_rst) begin m_stat = 0; m_cmd = 0; end
        end
    end

    function automatic logic exp_bit(input int b);
        if (b < 32)       return 1'b1;
        else if (b == 32) return 1'b0;
        else if (b == 33) return 1'b1;
        else if (b == 34) return m_rd;
        else if (b == 35) return !m_rd;
        else if (b <= 40) return m_fphy[40 - b];
        else if (b <= 45) return m_freg[45 - b];
        else if (b == 46) return 1'b1;
        else if (b == 47) return 1'b0;
        else              return m_fdata[63 - b];
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {m_cfg_rst, 27'd0, m_clksel};
            3'd1: return {19'd0, m_phy, 3'd0, m_reg};
            3'd2: return {16'd0, m_ctrl};
            3'd3: return {31'd0, m_cmd};
            3'd4: return {16'd0, m_stat};
            3'd5: return {29'd0, m_nv, 1'b0, m_busy};
            3'd6: return {27'd0, m_tbi};
            default: return 32'd0;
        endcase
    endfunction

    // PHY responder: drives read data during the data phase
    always @(negedge clk) begin
        if (m_busy && m_rd && (m_cnt / DIV) >= 48) mdio_i = phy_resp[63 - m_cnt / DIV];
        else                                      mdio_i = 1'b1;
    end

    // per-cycle comparison against the model
    int  mdc_rises = 0;
    logic mdc_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int   b     = m_cnt / DIV;
            automatic logic e_mdc = m_busy && ((m_cnt % DIV) >= HALF);
            automatic logic e_oe  = m_busy && !(m_rd && b >= 46);
            automatic logic e_o   = e_oe ? exp_bit(b) : 1'b0;
            check(mdc === e_mdc, "R7 mdc", {31'd0, mdc}, {31'd0, e_mdc});
            check(mdio_oe === e_oe, "R5 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            check(mdio_o === e_o, "R3 mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
            check(reg_rdata === exp_rdata(reg_addr), "R6 rdata", reg_rdata, exp_rdata(reg_addr));
        end
        if (mdc && !mdc_prev) mdc_rises++;
        mdc_prev = mdc;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wen = 1'b0; reg_addr = 3'd5;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
        reg_addr = 3'd5;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk); #1;
            if (reg_rdata[0] == 1'b0) break;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'd0, "R1 reset reg");
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {30'd0, mdc, mdio_oe}, 32'd0);

        // R10 / R2 field masks
        wr(3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd6, 32'h0000_001F, "R10 tbi mask");
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h0000_1F1F, "R2 addr mask");
        wr(3'd1, 32'h0000_1104);
        rd_chk(3'd1, 32'h0000_1104, "R2 addr fields");

        // R3 write frame, R8 writes ignored while busy
        mdc_rises = 0;
        wr(3'd2, 32'hABCD_5A3C);
        rd_chk(3'd5, 32'h1, "R6 busy on write");
        wr(3'd1, 32'h0000_0707);
        wr(3'd2, 32'h0000_1111);
        wr(3'd3, 32'h1);
        wr(3'd6, 32'h5);
        rd_chk(3'd1, 32'h0000_1104, "R8 addr held");
        rd_chk(3'd2, 32'h0000_5A3C, "R8 ctrl held");
        rd_chk(3'd3, 32'h0, "R8 cmd held");
        rd_chk(3'd6, 32'h5, "R10 tbi while busy");
        wait_idle();
        check(mdc_rises == 64, "R7 mdc periods", 32'(mdc_rises), 32'd64);
        rd_chk(3'd5, 32'h0, "R6 idle after write");

        // R5 read frame
        phy_resp = 16'hA5C3;
        wr(3'd3, 32'h1);
        rd_chk(3'd5, 32'h5, "R6 busy and not-valid");
        wait_idle();
        rd_chk(3'd4, 32'h0000_A5C3, "R5 read data");
        rd_chk(3'd5, 32'h0, "R6 flags clear");

        // R4 re-arm rule
        wr(3'd3, 32'h1);
        rd_chk(3'd5, 32'h0, "R4 no start without edge");
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0000_1F1F);
        phy_resp = 16'h3C5A;
        wr(3'd3, 32'h1);
        rd_chk(3'd5, 32'h5, "R4 start on rising edge");
        wait_idle();
        rd_chk(3'd4, 32'h0000_3C5A, "R4 second read data");

        // R9 management reset mid-frame
        wr(3'd3, 32'h0);
        wr(3'd2, 32'h0000_1234);
        repeat (500) @(posedge clk);
        wr(3'd0, 32'h8000_0005);
        @(posedge clk); #2;
        rd_chk(3'd5, 32'h0, "R9 frame aborted");
        check(mdc == 1'b0, "R9 mdc low", {31'd0, mdc}, 32'd0);
        rd_chk(3'd0, 32'h8000_0005, "R9 cfg readback");
        rd_chk(3'd4, 32'h0, "R9 status cleared");
        wr(3'd2, 32'h0000_0001);
        @(posedge clk); #2;
        rd_chk(3'd5, 32'h0, "R9 trigger ignored");
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0000_00FF);
        rd_chk(3'd5, 32'h1, "R3 write after reset release");
        wait_idle();
        rd_chk(3'd2, 32'h0000_00FF, "R3 ctrl readback");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule